// File: doc/BRIEF.md
# Satisfiability Search Sequencer

This block is the control state machine for a hardware Boolean satisfiability search over `NVAR` variables (8 by default). It makes decisions one variable at a time, in ascending index order, and always picks the lowest-index variable that is not yet assigned or implied. The first try for each decision is the value 0. After every decision it waits while the clause array reports new implications. When the clause array raises a conflict, the block strobes conflict-clause identification. It then backtracks to a level given by the external backtrack-level logic, clears the per-variable state that the backtrack undoes, and re-applies the decision at that level with the opposite value.

The block records the decision level at which each variable's status bit rose. It uses these levels to build the clear mask for a backtrack. It also keeps a per-level record of decisions that have already been tried both ways. A backtrack onto such a level moves further down, toward level 0. If no level is left to flip, the search reports unsatisfiable. If every variable is assigned or implied when a new decision is due, the search reports satisfiable. Both outcomes hold until `start` drops.

States and transitions:
- IDLE goes to REFRESH on `start`.
- REFRESH goes to PRECHARGE.
- PRECHARGE goes to ASSIGN.
- ASSIGN goes to WAIT after a decision, or to SAT when no variable is free.
- WAIT goes to ANALYZE on a conflict, stays in WAIT on an implication pulse, and otherwise goes to ASSIGN.
- ANALYZE goes to EXECUTE.
- EXECUTE goes to PRECHARGE when a level is available to flip, or to UNSAT when none is.
- SAT and UNSAT go to IDLE when `start` is low.

Top module: `sat_search_ctl`

## Requirements
- R1: After reset the block is idle. `done`, `sat`, `unsat`, `assign_en`, `refresh`, `precharge`, `ident_cclause` and `var_clr` are all 0, and they stay so until `start` is seen high.
- R2: On `start`, the block spends one cycle with `refresh`=1 and `var_clr` all ones. It then spends one cycle with `precharge`=1, and the cycle after that is a decision cycle.
- R3: A new decision drives `assign_en`=1 for one cycle. `assign_idx` is the lowest index whose `var_done` bit is 0, and `assign_val` is 0. The following cycle is an implication wait with `assign_en`=0.
- R4: The implication wait repeats for every cycle in which `new_impl` is 1 and `conflict` is 0. The next decision comes in the cycle after `new_impl` and `conflict` are both seen low.
- R5: `conflict` seen high in the implication wait gives exactly one cycle with `ident_cclause`=1, and then one backtrack cycle.
- R6: The resume level is the smaller of `bck_lvl` and the deepest current decision level, lowered further if needed (see R8). In the backtrack cycle, `var_clr` is 1 exactly for the variables whose recorded decision level is at or above the resume level. A precharge cycle follows.
- R7: The first decision after a backtrack re-decides the variable of the resume level with the opposite of its earlier value (0 becomes 1). Decisions after that return to the R3 rule.
- R8: A level whose decision has already been flipped is skipped. The resume level is the highest unflipped level at or below the clamped backtrack level.
- R9: When no unflipped level exists, the backtrack cycle drives `var_clr`=0 and the block enters the unsatisfiable outcome: `done`=1, `unsat`=1, `sat`=0.
- R10: When a decision is due and every `var_done` bit is 1, no assignment is made and the block enters the satisfiable outcome: `done`=1, `sat`=1, `unsat`=0. `sat` and `unsat` are never both 1.
- R11: An outcome holds while `start` is 1. In the cycle after `start` is seen low, the block is idle again with `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search; hold high to keep the outcome |
| new_impl | input | 1 | Wired-OR one-cycle pulse for a new implication |
| conflict | input | 1 | Conflict present in the clause array |
| bck_lvl | input | $clog2(NVAR) | Backtrack level from the external level logic |
| var_done | input | NVAR | Per-variable assigned-or-implied status |
| assign_en | output | 1 | Decision strobe |
| assign_idx | output | $clog2(NVAR) | Variable to decide |
| assign_val | output | 1 | Value of the decision |
| refresh | output | 1 | Array refresh strobe |
| precharge | output | 1 | Array precharge strobe |
| var_clr | output | NVAR | Per-variable clear enables |
| ident_cclause | output | 1 | Identify-conflict-clause strobe |
| done | output | 1 | Search finished |
| sat | output | 1 | Outcome: satisfiable |
| unsat | output | 1 | Outcome: unsatisfiable |

## Verification
A wrongly recorded decision level for a variable shows up in the backtrack cycle, as a wrong bit in `var_clr`. The next decision then shows the same fault, because it has the wrong `assign_idx`. A corrupted flipped record or decision value shows up in the decision cycle two cycles after the backtrack: the index or polarity is wrong, or the block ends in an early or missing unsatisfiable outcome. A bench sweep over every backtrack level at a fixed depth compares the clear mask with an arithmetic prediction, and directed runs cover implication holds, a double backtrack down to level 0, and both outcomes.

// File: rtl/sat_ctl_pkg.sv
package sat_ctl_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_REFRESH,
        ST_PRECHARGE,
        ST_ASSIGN,
        ST_WAIT,
        ST_ANALYZE,
        ST_EXECUTE,
        ST_SAT,
        ST_UNSAT
    } ctl_state_e;
endpackage

// File: rtl/sat_pick_free.sv
module sat_pick_free #(
    parameter int NVAR = 8,
    parameter int IW   = $clog2(NVAR)
) (
    input  logic [NVAR-1:0] status,
    output logic            any_free,
    output logic [IW-1:0]   idx
);
    // lowest index with a clear status bit wins
    always_comb begin
        any_free = 1'b0;
        idx      = '0;
        for (int i = NVAR - 1; i >= 0; i--) begin
            if (!status[i]) begin
                any_free = 1'b1;
                idx      = IW'(i);
            end
        end
    end
endmodule

// File: rtl/sat_level_track.sv
module sat_level_track #(
    parameter int NVAR = 8,
    parameter int LW   = $clog2(NVAR)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NVAR-1:0] status,
    input  logic [NVAR-1:0] clr,
    input  logic [LW-1:0]   cur_lvl,
    input  logic [LW-1:0]   resume_lvl,
    output logic [NVAR-1:0] at_or_above
);
    for (genvar g = 0; g < NVAR; g++) begin : g_var
        logic          rec;
        logic [LW-1:0] lvl;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rec <= 1'b0;
                lvl <= '0;
            end else if (clr[g]) begin
                rec <= 1'b0;
            end else if (status[g] && !rec) begin
                rec <= 1'b1;
                lvl <= cur_lvl;
            end
        end

        assign at_or_above[g] = rec && (lvl >= resume_lvl);
    end
endmodule

// File: rtl/sat_resume_select.sv
module sat_resume_select #(
    parameter int NVAR = 8,
    parameter int LW   = $clog2(NVAR),
    parameter int NW   = $clog2(NVAR + 1)
) (
    input  logic [NVAR-1:0] flipped,
    input  logic [NW-1:0]   ndec,
    input  logic [LW-1:0]   bck,
    output logic            found,
    output logic [LW-1:0]   tgt
);
    logic [NW-1:0] cap;
    logic [NW-1:0] lim;

    always_comb begin
        cap   = (ndec == '0) ? '0 : ndec - NW'(1);
        lim   = (NW'(bck) > cap) ? cap : NW'(bck);
        found = 1'b0;
        tgt   = '0;
        // ascending scan: the highest qualifying level is kept
        for (int l = 0; l < NVAR; l++) begin
            if ((ndec != '0) && (NW'(l) <= lim) && !flipped[l]) begin
                found = 1'b1;
                tgt   = LW'(l);
            end
        end
    end
endmodule

// File: rtl/sat_search_ctl.sv
module sat_search_ctl
    import sat_ctl_pkg::*;
#(
    parameter int NVAR = 8,
    parameter int IW   = $clog2(NVAR),
    parameter int NW   = $clog2(NVAR + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            new_impl,
    input  logic            conflict,
    input  logic [IW-1:0]   bck_lvl,
    input  logic [NVAR-1:0] var_done,
    output logic            assign_en,
    output logic [IW-1:0]   assign_idx,
    output logic            assign_val,
    output logic            refresh,
    output logic            precharge,
    output logic [NVAR-1:0] var_clr,
    output logic            ident_cclause,
    output logic            done,
    output logic            sat,
    output logic            unsat
);
    ctl_state_e state, state_nx;

    logic [NW-1:0]   ndec;
    logic            flip_pend;
    logic [IW-1:0]   flip_lvl;
    logic [IW-1:0]   dec_var [NVAR];
    logic [NVAR-1:0] dec_val;
    logic [NVAR-1:0] flipped;

    logic            any_free;
    logic [IW-1:0]   pick;
    logic            found;
    logic [IW-1:0]   tgt;
    logic [NVAR-1:0] undo_mask;
    logic [IW-1:0]   cur_lvl;

    sat_pick_free #(.NVAR(NVAR), .IW(IW)) u_pick (
        .status   (var_done),
        .any_free (any_free),
        .idx      (pick)
    );

    sat_resume_select #(.NVAR(NVAR), .LW(IW), .NW(NW)) u_resume (
        .flipped (flipped),
        .ndec    (ndec),
        .bck     (bck_lvl),
        .found   (found),
        .tgt     (tgt)
    );

    sat_level_track #(.NVAR(NVAR), .LW(IW)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .status      (var_done),
        .clr         (var_clr),
        .cur_lvl     (cur_lvl),
        .resume_lvl  (tgt),
        .at_or_above (undo_mask)
    );

    // level stamped on a status bit that rises at the end of this cycle
    always_comb begin
        if (state == ST_ASSIGN)
            cur_lvl = flip_pend ? flip_lvl : IW'(ndec);
        else
            cur_lvl = (ndec == '0) ? '0 : IW'(ndec - NW'(1));
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (start) state_nx = ST_REFRESH;
            ST_REFRESH:   state_nx = ST_PRECHARGE;
            ST_PRECHARGE: state_nx = ST_ASSIGN;
            ST_ASSIGN:    state_nx = (flip_pend || any_free) ? ST_WAIT : ST_SAT;
            ST_WAIT: begin
                if (conflict)      state_nx = ST_ANALYZE;
                else if (new_impl) state_nx = ST_WAIT;
                else               state_nx = ST_ASSIGN;
            end
            ST_ANALYZE:   state_nx = ST_EXECUTE;
            ST_EXECUTE:   state_nx = found ? ST_PRECHARGE : ST_UNSAT;
            ST_SAT,
            ST_UNSAT:     if (!start) state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // state register and decision stack
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            ndec      <= '0;
            flip_pend <= 1'b0;
            flip_lvl  <= '0;
            dec_val   <= '0;
            flipped   <= '0;
            for (int l = 0; l < NVAR; l++) dec_var[l] <= '0;
        end else begin
            state <= state_nx;
            unique case (state)
                ST_REFRESH: begin
                    ndec      <= '0;
                    flipped   <= '0;
                    flip_pend <= 1'b0;
                end
                ST_ASSIGN: begin
                    if (flip_pend) begin
                        dec_val[flip_lvl] <= ~dec_val[flip_lvl];
                        flipped[flip_lvl] <= 1'b1;
                        ndec              <= NW'(flip_lvl) + NW'(1);
                        flip_pend         <= 1'b0;
                    end else if (any_free) begin
                        dec_var[IW'(ndec)] <= pick;
                        dec_val[IW'(ndec)] <= 1'b0;
                        flipped[IW'(ndec)] <= 1'b0;
                        ndec               <= ndec + NW'(1);
                    end
                end
                ST_EXECUTE: begin
                    if (found) begin
                        flip_pend <= 1'b1;
                        flip_lvl  <= tgt;
                        ndec      <= NW'(tgt);
                        for (int l = 0; l < NVAR; l++)
                            if (IW'(l) > tgt) flipped[l] <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        assign_en     = (state == ST_ASSIGN) && (flip_pend || any_free);
        assign_idx    = flip_pend ? dec_var[flip_lvl] : pick;
        assign_val    = flip_pend ? ~dec_val[flip_lvl] : 1'b0;
        refresh       = (state == ST_REFRESH);
        precharge     = (state == ST_PRECHARGE);
        ident_cclause = (state == ST_ANALYZE);
        sat           = (state == ST_SAT);
        unsat         = (state == ST_UNSAT);
        done          = sat || unsat;
        if (state == ST_REFRESH)
            var_clr = '1;
        else if ((state == ST_EXECUTE) && found)
            var_clr = undo_mask;
        else
            var_clr = '0;
    end

    // R2: refresh is followed by precharge
    assert_refresh_then_pre_R2: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |=> precharge);
    // R3: a decision strobe lasts one cycle
    assert_assign_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        assign_en |=> !assign_en);
    // R4: an implication pulse without conflict keeps the wait
    assert_wait_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && new_impl && !conflict) |=> (state == ST_WAIT));
    // R5: identification is a single cycle with no decision after it
    assert_ident_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ident_cclause |=> (!ident_cclause && !assign_en));
    // R10: outcomes exclusive
    assert_outcome_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(sat && unsat));
    // R11: outcome holds while start stays high
    assert_outcome_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> done);
endmodule

// File: tb/tb_sat_search_ctl.sv
module tb_sat_search_ctl;
    localparam int NV = 8;
    localparam int IW = $clog2(NV);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          new_impl = 1'b0;
    logic          conflict = 1'b0;
    logic [IW-1:0] bck_lvl = '0;
    logic [NV-1:0] var_done = '0;
    logic          assign_en, assign_val, refresh, precharge, ident_cclause;
    logic          done, sat, unsat;
    logic [IW-1:0] assign_idx;
    logic [NV-1:0] var_clr;

    logic [NV-1:0] pend_set = '0;
    logic [NV-1:0] pend_clr = '0;
    int checks = 0;
    int errors = 0;
    int cycles = 0;

    sat_search_ctl #(.NVAR(NV)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .new_impl(new_impl),
        .conflict(conflict), .bck_lvl(bck_lvl), .var_done(var_done),
        .assign_en(assign_en), .assign_idx(assign_idx), .assign_val(assign_val),
        .refresh(refresh), .precharge(precharge), .var_clr(var_clr),
        .ident_cclause(ident_cclause), .done(done), .sat(sat), .unsat(unsat)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: got %0d expected %0d", cycles, 20000);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // one cycle of the modelled clause array: status follows decisions and
    // clears with a one-cycle latency
    task automatic cyc();
        @(negedge clk);
        var_done = (var_done & ~pend_clr) | pend_set;
        #1;
        pend_clr = var_clr;
        pend_set = '0;
        if (assign_en) pend_set[assign_idx] = 1'b1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; start = 1'b0; new_impl = 1'b0; conflict = 1'b0;
        bck_lvl = '0; var_done = '0; pend_set = '0; pend_clr = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic chk_assign(input string req, input int idx, input int val);
        chk({req, " assign_en"}, int'(assign_en), 1);
        chk({req, " idx"}, int'(assign_idx), idx);
        chk({req, " val"}, int'(assign_val), val);
    endtask

    task automatic begin_search();
        start = 1'b1;
        cyc();
        chk("R2 refresh", int'(refresh), 1);
        chk("R2 clear all", int'(var_clr), (1 << NV) - 1);
        cyc();
        chk("R2 precharge", int'(precharge), 1);
        cyc();
    endtask

    initial begin
        // ---------- satisfiable run with implications ----------
        do_reset();
        cyc();
        chk("R1 idle done", int'(done), 0);
        chk("R1 idle strobes", int'({assign_en, refresh, precharge, ident_cclause, sat, unsat}), 0);
        chk("R1 idle clr", int'(var_clr), 0);
        cyc();
        chk("R1 no start", int'(refresh), 0);
        begin_search();
        chk_assign("R3 first", 0, 0);
        new_impl = 1'b1;
        pend_set[3] = 1'b1;
        cyc();
        chk("R3 wait after decide", int'(assign_en), 0);
        pend_set[4] = 1'b1;
        cyc();
        chk("R4 held by pulse", int'(assign_en), 0);
        new_impl = 1'b0;
        cyc();
        chk_assign("R4 after pulses", 1, 0);
        cyc();
        cyc(); chk_assign("R3 second", 2, 0);
        cyc();
        cyc(); chk_assign("R3 skip implied", 5, 0);
        cyc();
        cyc(); chk_assign("R3 next", 6, 0);
        cyc();
        cyc(); chk_assign("R3 last", 7, 0);
        cyc();
        cyc();
        chk("R10 no assign when full", int'(assign_en), 0);
        cyc();
        chk("R10 done", int'(done), 1);
        chk("R10 sat", int'(sat), 1);
        chk("R10 not unsat", int'(unsat), 0);
        cyc(); cyc();
        chk("R11 hold sat", int'(sat), 1);
        start = 1'b0;
        cyc();
        chk("R11 back to idle", int'(done), 0);

        // ---------- double backtrack ending unsatisfiable ----------
        do_reset();
        begin_search();
        chk_assign("R3 b0", 0, 0);
        cyc();
        cyc(); chk_assign("R3 b1", 1, 0);
        new_impl = 1'b1;
        pend_set[4] = 1'b1;
        cyc();
        cyc();
        chk("R4 hold b", int'(assign_en), 0);
        new_impl = 1'b0;
        cyc(); chk_assign("R3 b2", 2, 0);
        cyc();
        cyc(); chk_assign("R3 b3", 3, 0);
        conflict = 1'b1; bck_lvl = IW'(1);
        cyc();
        cyc();
        chk("R5 ident", int'(ident_cclause), 1);
        chk("R5 no clr in analyze", int'(var_clr), 0);
        conflict = 1'b0;
        cyc();
        chk("R5 single ident", int'(ident_cclause), 0);
        chk("R6 clear at level 1 and up", int'(var_clr), 8'h1E);
        cyc();
        chk("R6 precharge after", int'(precharge), 1);
        cyc(); chk_assign("R7 flipped decision", 1, 1);
        cyc();
        cyc(); chk_assign("R7 normal after flip", 2, 0);
        conflict = 1'b1; bck_lvl = IW'(1);
        cyc();
        cyc();
        conflict = 1'b0;
        cyc();
        chk("R8 skip flipped level", int'(var_clr), 8'h07);
        cyc();
        cyc(); chk_assign("R8 flip level 0", 0, 1);
        conflict = 1'b1; bck_lvl = IW'(0);
        cyc();
        cyc();
        conflict = 1'b0;
        cyc();
        chk("R9 no clear", int'(var_clr), 0);
        cyc();
        chk("R9 done", int'(done), 1);
        chk("R9 unsat", int'(unsat), 1);
        chk("R9 not sat", int'(sat), 0);
        cyc();
        chk("R11 hold unsat", int'(unsat), 1);
        start = 1'b0;
        cyc();
        chk("R11 idle", int'(done), 0);

        // ---------- sweep of backtrack level at depth 4 ----------
        for (int b = 0; b < NV; b++) begin
            int t;
            t = (b > 3) ? 3 : b;
            do_reset();
            begin_search();
            for (int k = 0; k < 4; k++) begin
                chk_assign("R3 sweep", k, 0);
                if (k == 3) begin
                    conflict = 1'b1;
                    bck_lvl = IW'(b);
                end
                cyc();
                if (k < 3) cyc();
            end
            cyc();
            chk("R5 sweep ident", int'(ident_cclause), 1);
            conflict = 1'b0;
            cyc();
            chk("R6 sweep mask", int'(var_clr), 8'h0F & ~((1 << t) - 1));
            cyc();
            cyc();
            chk_assign("R7 sweep flip", t, 1);
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule